// File: doc/BRIEF.md
# Prescaled Countdown Timer with Vector Delivery

This block is a 32-bit countdown timer for an interrupt controller. A prescaler divides an incoming tick strobe by a power of two between 1 and 128. Each divided tick takes one off the current count. When the count runs out, the timer raises a request for the vector held in its configuration entry, unless that entry is masked. In one-shot mode it then stops at zero. In periodic mode it reloads from the initial count and runs again.

Software writes three things: the initial count (which restarts the countdown), the current count (which overrides the running value), and the configuration entry. The divide code is a level input. The raise strobe and its vector go to the request tracker of the interrupt controller. A zero initial count keeps the timer idle. A divide code outside the valid range freezes the countdown and raises an error flag.

Top module: `vt_timer`

## Requirements
- R1: After reset, `count_o` is 0, `raise_o` is low, `div_err_o` is low and `entry_o` reads 0x00010000 (masked, one-shot, vector 0).
- R2: A divide code c in 0..7 makes the count drop by one every 2^c cycles in which `tick_i` is high. Cycles with `tick_i` low are not counted. The prescaler restarts on an initial-count write, so the first decrement comes 2^c ticks after that write.
- R3: A divide code of 8 or above (bit 3 set) asserts `div_err_o` and the count holds its value.
- R4: An initial-count write loads the current count with the same value. While the initial count is zero the count never changes by itself and no raise is issued.
- R5: A current-count write replaces the running count, and the countdown continues from the written value.
- R6: A decrement from 1 sets the count to 0 and produces an expiry. The resulting `raise_o` is a single-cycle pulse in the next cycle, with `raise_vec_o` equal to entry bits [7:0], and `count_o` reads 0 in that cycle.
- R7: When entry bit 16 (mask) is 1, an expiry produces no raise.
- R8: With entry bit 17 = 0 (one-shot), the count stays at 0 after expiry and no further raise follows.
- R9: With entry bit 17 = 1 (periodic), the first prescaled tick after expiry reloads the initial count. An initial count N therefore gives one raise every (N+1)*2^c ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick strobe that feeds the prescaler |
| div_code_i | input | CODE_W | Divide select: 0..7 means divide by 2^code, anything else is invalid |
| init_we_i | input | 1 | Initial-count write strobe |
| init_val_i | input | CNT_W | Initial-count write data |
| cur_we_i | input | 1 | Current-count write strobe |
| cur_val_i | input | CNT_W | Current-count write data |
| entry_we_i | input | 1 | Configuration entry write strobe |
| entry_val_i | input | 32 | Entry data: vector [7:0], mask [16], periodic [17] |
| count_o | output | CNT_W | Current count |
| entry_o | output | 32 | Configuration entry as stored |
| raise_o | output | 1 | One-cycle request to raise a vector |
| raise_vec_o | output | 8 | Vector that goes with `raise_o` |
| div_err_o | output | 1 | Divide code is invalid |

## Verification
The bench uses the default parameters: a 32-bit count, a 7-bit prescaler and a 4-bit divide code. With a 4-bit code, the invalid codes 8 to 15 can be driven alongside the eight valid divisors. The counter is 32 bits wide, but small initial counts bring expiry, periodic reload and current-count override within a few dozen cycles. Raise times are predicted from the write cycle, the count and 2^c, and the bench compares each one to the exact cycle.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int unsigned ENTRY_W  = 32;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MASK_POS = 16;
  localparam int unsigned MODE_POS = 17;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 32'h0001_0000;

  typedef enum logic {MODE_ONESHOT = 1'b0, MODE_PERIODIC = 1'b1} tmr_mode_e;

  typedef struct packed {
    logic             masked;
    tmr_mode_e        mode;
    logic [VEC_W-1:0] vec;
  } entry_cfg_t;

  function automatic entry_cfg_t decode_entry(input logic [ENTRY_W-1:0] e);
    entry_cfg_t c;
    c.masked = e[MASK_POS];
    c.mode   = tmr_mode_e'(e[MODE_POS]);
    c.vec    = e[VEC_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/vt_prescaler.sv
module vt_prescaler #(
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              step_o,
  output logic              div_err_o
);
  localparam int unsigned NSEL = PRE_W + 1;
  localparam int unsigned SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1;
  localparam logic [CODE_W-1:0] NSEL_C = CODE_W'(NSEL);

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  hit;
  logic [SEL_W-1:0] sel;
  logic             valid;

  // hit[g]: the low g prescaler bits are all ones, so the next tick ends a 2^g window
  for (genvar g = 0; g < NSEL; g++) begin : g_hit
    if (g == 0) begin : g_div1
      assign hit[g] = 1'b1;
    end else begin : g_divn
      assign hit[g] = &pre_q[g-1:0];
    end
  end

  assign valid     = (code_i < NSEL_C);
  assign sel       = code_i[SEL_W-1:0];
  assign div_err_o = !valid;
  assign step_o    = tick_i && valid && hit[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/vt_counter.sv
module vt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             init_we_i,
  input  logic [CNT_W-1:0] init_val_i,
  input  logic             cur_we_i,
  input  logic [CNT_W-1:0] cur_val_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] init_q, cur_q, cur_d;
  logic             reload_q, reload_d, fire;

  always_comb begin
    cur_d    = cur_q;
    reload_d = reload_q;
    fire     = 1'b0;
    if (cur_we_i) begin
      cur_d    = cur_val_i;
      reload_d = 1'b0;
    end else if (step_i && init_q != '0) begin
      if (cur_q == '0) begin
        if (periodic_i && reload_q) begin
          cur_d    = init_q;
          reload_d = 1'b0;
        end else if (periodic_i) begin
          fire     = 1'b1;   // zero written while periodic: expire now
          reload_d = 1'b1;
        end
      end else if (cur_q == ONE) begin
        cur_d    = '0;
        fire     = 1'b1;
        reload_d = periodic_i;
      end else begin
        cur_d = cur_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= '0;
      cur_q    <= '0;
      reload_q <= 1'b0;
    end else if (init_we_i) begin
      init_q   <= init_val_i;
      cur_q    <= init_val_i;
      reload_q <= 1'b0;
    end else begin
      cur_q    <= cur_d;
      reload_q <= reload_d;
    end
  end

  assign count_o = cur_q;
  assign fire_o  = fire && !init_we_i;

  p_zero_init_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q == '0 && !init_we_i && !cur_we_i) |=> $stable(cur_q));

  p_oneshot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic_i && cur_q == '0 && !init_we_i && !cur_we_i) |=> (cur_q == '0));
endmodule

// File: rtl/vt_deliver.sv
module vt_deliver
  import vt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               entry_we_i,
  input  logic [ENTRY_W-1:0] entry_val_i,
  input  logic               fire_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               periodic_o,
  output logic               raise_o,
  output logic [VEC_W-1:0]   raise_vec_o
);
  logic [ENTRY_W-1:0] entry_q;
  entry_cfg_t         cfg;
  logic               masked;
  logic               raise_q;
  logic [VEC_W-1:0]   vec_q;

  assign cfg        = decode_entry(entry_q);
  assign masked     = cfg.masked;
  assign periodic_o = (cfg.mode == MODE_PERIODIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= ENTRY_RST;
      raise_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (entry_we_i) entry_q <= entry_val_i;
      raise_q <= fire_i && !masked;
      if (fire_i) vec_q <= cfg.vec;
    end
  end

  assign entry_o     = entry_q;
  assign raise_o     = raise_q;
  assign raise_vec_o = vec_q;

  p_mask_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_o |-> !$past(masked));
endmodule

// File: rtl/vt_timer.sv
module vt_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              init_we_i,
  input  logic [CNT_W-1:0]  init_val_i,
  input  logic              cur_we_i,
  input  logic [CNT_W-1:0]  cur_val_i,
  input  logic              entry_we_i,
  input  logic [31:0]       entry_val_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [31:0]       entry_o,
  output logic              raise_o,
  output logic [7:0]        raise_vec_o,
  output logic              div_err_o
);
  logic step, fire, periodic;

  vt_prescaler #(.PRE_W(PRE_W), .CODE_W(CODE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (init_we_i),
    .code_i    (div_code_i),
    .step_o    (step),
    .div_err_o (div_err_o)
  );

  vt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .init_we_i  (init_we_i),
    .init_val_i (init_val_i),
    .cur_we_i   (cur_we_i),
    .cur_val_i  (cur_val_i),
    .periodic_i (periodic),
    .count_o    (count_o),
    .fire_o     (fire)
  );

  vt_deliver u_dlv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_we_i  (entry_we_i),
    .entry_val_i (entry_val_i),
    .fire_i      (fire),
    .entry_o     (entry_o),
    .periodic_o  (periodic),
    .raise_o     (raise_o),
    .raise_vec_o (raise_vec_o)
  );

  p_raise_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_o |-> (count_o == '0));

  p_raise_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_o |=> !raise_o);

  p_bad_div_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_err_o && !init_we_i && !cur_we_i) |=> $stable(count_o));
endmodule

// File: tb/sim_vt_timer.sv
`timescale 1ns/1ps
module sim_vt_timer;
  localparam int CNT_W = 32, PRE_W = 7, CODE_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [CODE_W-1:0] div_code = '0;
  logic init_we = 1'b0, cur_we = 1'b0, entry_we = 1'b0;
  logic [CNT_W-1:0] init_val = '0, cur_val = '0;
  logic [31:0] entry_val = '0;
  logic [CNT_W-1:0] count;
  logic [31:0] entry;
  logic raise, div_err;
  logic [7:0] raise_vec;

  always #2.5 clk = ~clk;

  vt_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .CODE_W(CODE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .div_code_i(div_code),
    .init_we_i(init_we), .init_val_i(init_val), .cur_we_i(cur_we), .cur_val_i(cur_val),
    .entry_we_i(entry_we), .entry_val_i(entry_val), .count_o(count), .entry_o(entry),
    .raise_o(raise), .raise_vec_o(raise_vec), .div_err_o(div_err)
  );

  typedef struct { longint at; logic [7:0] vec; } exp_t;
  exp_t q[$];
  int errs = 0, checks = 0;
  longint cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected raises as the design produces them
  always @(negedge clk) begin
    if (rst_n && raise) begin
      if (q.size() == 0) chk(0, "R7", "unexpected raise at cycle", cyc, -1);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.at, "R6", "raise cycle", cyc, e.at);
        chk(raise_vec == e.vec, "R6", "raise vector", raise_vec, e.vec);
        chk(count == 0, "R6", "count at raise", count, 0);
      end
    end
  end

  task automatic push(input longint at, input logic [7:0] v);
    exp_t e;
    e.at = at; e.vec = v;
    q.push_back(e);
  endtask

  task automatic wr_entry(input logic [31:0] v);
    @(negedge clk); entry_we = 1; entry_val = v;
    @(negedge clk); entry_we = 0;
  endtask

  task automatic wr_init(input logic [CNT_W-1:0] v, output longint t0);
    @(negedge clk); init_we = 1; init_val = v;
    @(negedge clk); init_we = 0; t0 = cyc;
  endtask

  task automatic wr_cur(input logic [CNT_W-1:0] v, output longint t0);
    @(negedge clk); cur_we = 1; cur_val = v;
    @(negedge clk); cur_we = 0; t0 = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    longint t0, t1;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk(count == 0, "R1", "count after reset", count, 0);
    chk(raise == 0, "R1", "raise after reset", raise, 0);
    chk(div_err == 0, "R1", "div_err after reset", div_err, 0);
    chk(entry == 32'h0001_0000, "R1", "entry after reset", entry, 32'h0001_0000);

    // R4 zero initial count keeps timer idle, even periodic and unmasked
    wr_entry(32'h0002_0033);
    wr_init(0, t0);
    idle(40);
    chk(count == 0, "R4", "count with zero init", count, 0);

    // R6/R8 one-shot, divide by 1
    wr_entry(32'h0000_0041);
    wr_init(5, t0);
    chk(count == 5, "R4", "init loads count", count, 5);
    push(t0 + 5, 8'h41);
    idle(30);
    chk(count == 0, "R8", "one-shot stays zero", count, 0);
    chk(q.size() == 0, "R8", "pending raises after one-shot", q.size(), 0);

    // R2 divide by 4, then tick gating
    div_code = 4'd2;
    wr_init(100, t0);
    idle(20);
    chk(count == 95, "R2", "count after 20 ticks at div4", count, 95);
    tick = 0;
    idle(10);
    chk(count == 95, "R2", "count with tick low", count, 95);
    tick = 1;
    wr_init(0, t0);

    // R9 periodic, divide by 2, N=3 -> period 8
    div_code = 4'd1;
    wr_entry(32'h0002_0052);
    wr_init(3, t0);
    push(t0 + 6, 8'h52);
    push(t0 + 14, 8'h52);
    push(t0 + 22, 8'h52);
    idle(8);
    chk(count == 3, "R9", "reload after expiry", count, 3);
    idle(17);
    wr_init(0, t1);
    idle(5);
    chk(q.size() == 0, "R9", "periodic raises missing", q.size(), 0);

    // R7 masked entry
    div_code = 4'd0;
    wr_entry(32'h0001_0077);
    wr_init(4, t0);
    idle(10);
    chk(count == 0, "R7", "masked timer still expires", count, 0);
    chk(q.size() == 0, "R7", "queue after masked run", q.size(), 0);

    // R3 invalid divide code
    div_code = 4'b1000;
    idle(1);
    chk(div_err == 1, "R3", "div_err with code 8", div_err, 1);
    wr_init(10, t0);
    idle(30);
    chk(count == 10, "R3", "count frozen by bad code", count, 10);
    div_code = 4'd0;
    idle(1);
    chk(div_err == 0, "R3", "div_err with code 0", div_err, 0);
    wr_init(0, t0);

    // R5 current-count override
    wr_entry(32'h0000_0019);
    wr_init(50, t0);
    idle(3);
    chk(count == 47, "R5", "count before override", count, 47);
    wr_cur(2, t1);
    push(t1 + 2, 8'h19);
    idle(10);
    chk(count == 0, "R5", "count after override expiry", count, 0);
    chk(q.size() == 0, "R5", "raise from override", q.size(), 0);

    done = 1;
    finish_run();
  end
endmodule